// File: doc/BRIEF.md
# Mesh-Decomposed 2D Transform Burst Address Sequencer

This block walks an N×N complex image held in external memory, in row-major order with one word per sample, through the two passes of a two-dimensional transform computed by mesh decomposition. The image is divided into a mesh of K×K sub-blocks. An on-chip tile buffer of S×S words is filled, handed to compute, and drained. For every tile the sequencer issues read bursts, each a start address and a length, through a valid/ready request port. It then raises a tile-ready flag and waits for the compute engines to report completion. After that it issues the same bursts again as writes. When the last write burst of the last tile has been accepted, it pulses done.

In the exchange pass, a tile collects the same window of in-block positions from every sub-block of the mesh. The window is (S·K/N) positions on a side. In the local pass, a tile is an S×S square of whole, contiguous sub-blocks. Both passes use only row-contiguous bursts, so the column-direction gather of the exchange pass never becomes strided single-word access. The pass and the three sizes are supplied as configuration inputs and are captured when a run starts.

Top module: `dft_tile_seq`

## Requirements
- R1: After reset, busy, req_valid, tile_ready and done are all low.
- R2: A start pulse seen while idle captures cfg_phase (0 = exchange pass, 1 = local pass) and the base-2 logarithms of N, K and S. A configuration is legal when K ≤ S, N/K ≤ S and S ≤ N. The word address of image sample (row, col) is row·N + col.
- R3: In the local pass, tile (ty, tx) issues S bursts, one for each r from 0 to S−1 in ascending order. Each burst has address (ty·S + r)·N + tx·S and length S.
- R4: In the exchange pass, let m = N/K and w = S/m. Tile (ty, tx) issues bursts for sub-block row br (outermost), then in-window row r, then sub-block column bc (innermost). Each burst has address (br·K + ty·w + r)·N + bc·K + tx·w and length w.
- R5: Every burst stays inside one image row (address mod N plus length ≤ N). A tile has S·N/K bursts in the exchange pass and S bursts in the local pass.
- R6: A run covers (N/S)² tiles in raster order, with tx varying fastest. Each tile is fully read and then fully written before the next tile starts.
- R7: The write bursts of a tile repeat that tile's read sequence exactly. req_write is 0 on every read and 1 on every write.
- R8: tile_ready rises only after the last read burst of a tile has been accepted. It stays high until cmp_done is seen. No request is presented while it is high.
- R9: done is a single-cycle pulse in the cycle after the last write burst of the last tile is accepted. busy is low from that cycle on.
- R10: start is ignored while busy; the running sequence and its configuration are unaffected.
- R11: While req_valid is high and req_ready is low, req_addr, req_len and req_write hold their values and req_valid stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run with the configuration on the cfg inputs |
| cfg_phase | input | 1 | Pass select: 0 exchange, 1 local |
| cfg_n_log2 | input | LW | log2 of image side N |
| cfg_k_log2 | input | LW | log2 of sub-block side K |
| cfg_s_log2 | input | LW | log2 of tile buffer side S |
| busy | output | 1 | High while a run is in progress |
| req_valid | output | 1 | Burst request present |
| req_ready | input | 1 | Memory side accepts the burst this cycle |
| req_write | output | 1 | 1 for a write-back burst, 0 for a load burst |
| req_addr | output | AW | Burst start word address |
| req_len | output | LENW | Burst length in words |
| tile_ready | output | 1 | Tile buffer loaded; compute may run |
| cmp_done | input | 1 | Compute on the current tile finished |
| done | output | 1 | One-cycle pulse at the end of a run |

## Verification
The bench uses the default MAX_N_LOG2 of 6, so configurations up to a 64×64 image are legal. It runs images of 8, 16 and 32 samples on a side. These sizes reach mesh widths of 2, 4 and 8 sub-blocks and exchange windows of 1, 2 and 4 positions, including the one-word-burst corner where the mesh is as wide as the tile. They also cover the single-tile local run, where S equals N. Both passes are run with an always-ready memory side and with pseudo-random back-pressure, and a second start with a different configuration is injected in the middle of a run.

// File: rtl/dft_tseq_pkg.sv
package dft_tseq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_HOLD  = 2'd2
  } seq_state_e;

  typedef enum logic {
    PH_EXCH  = 1'b0,
    PH_LOCAL = 1'b1
  } phase_e;

  // counter slots in the nested walk, innermost first
  localparam int CTR_SEG = 0;
  localparam int CTR_ROW = 1;
  localparam int CTR_TX  = 2;
  localparam int CTR_TY  = 3;
  localparam int N_CTR   = 4;

endpackage

// File: rtl/dft_tseq_wrapctr.sv
module dft_tseq_wrapctr #(
  parameter int CW = 6,
  parameter int LW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          adv,
  input  logic [LW-1:0] lim_log2,
  output logic [CW-1:0] cnt,
  output logic          last
);

  logic [CW:0]   one_sh;
  logic [CW-1:0] mask;

  assign one_sh = {{CW{1'b0}}, 1'b1} << lim_log2;
  assign mask   = one_sh[CW-1:0] - {{(CW-1){1'b0}}, 1'b1};
  assign last   = (cnt == mask);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (adv) begin
      cnt <= last ? '0 : cnt + {{(CW-1){1'b0}}, 1'b1};
    end
  end

  // R5: a walk index never leaves the range its limit defines
  a_r5_cnt_in_range: assert property (@(posedge clk) disable iff (rst)
    cnt <= mask);

endmodule

// File: rtl/dft_tseq_addr_map.sv
module dft_tseq_addr_map #(
  parameter int MAX_N_LOG2 = 6,
  localparam int LW   = $clog2(MAX_N_LOG2 + 1),
  localparam int CW   = MAX_N_LOG2,
  localparam int AW   = 2 * MAX_N_LOG2,
  localparam int LENW = MAX_N_LOG2 + 1
) (
  input  dft_tseq_pkg::phase_e phase,
  input  logic [LW-1:0]        n_log2,
  input  logic [LW-1:0]        k_log2,
  input  logic [LW-1:0]        s_log2,
  input  logic [CW-1:0]        row_i,
  input  logic [CW-1:0]        seg_j,
  input  logic [CW-1:0]        tile_y,
  input  logic [CW-1:0]        tile_x,
  output logic [AW-1:0]        addr,
  output logic [LENW-1:0]      len
);
  import dft_tseq_pkg::*;

  logic [LW-1:0] mesh_log2;
  logic [LW-1:0] win_log2;
  logic [AW-1:0] one_w, i_w, j_w, ty_w, tx_w;
  logic [AW-1:0] x_row, x_col, l_row, l_col, img_row, img_col;

  assign mesh_log2 = n_log2 - k_log2;
  assign win_log2  = s_log2 - mesh_log2;

  assign one_w = {{(AW-1){1'b0}}, 1'b1};
  assign i_w   = {{(AW-CW){1'b0}}, row_i};
  assign j_w   = {{(AW-CW){1'b0}}, seg_j};
  assign ty_w  = {{(AW-CW){1'b0}}, tile_y};
  assign tx_w  = {{(AW-CW){1'b0}}, tile_x};

  // exchange pass: tile row i splits into sub-block row (high) and window row (low)
  assign x_row = ((i_w >> win_log2) << k_log2)
               | (ty_w << win_log2)
               | (i_w & ((one_w << win_log2) - one_w));
  assign x_col = (j_w << k_log2) | (tx_w << win_log2);

  // local pass: a plain S x S square of the image
  assign l_row = (ty_w << s_log2) | i_w;
  assign l_col = tx_w << s_log2;

  always_comb begin
    if (phase == PH_LOCAL) begin
      img_row = l_row;
      img_col = l_col;
      len     = {{(LENW-1){1'b0}}, 1'b1} << s_log2;
    end else begin
      img_row = x_row;
      img_col = x_col;
      len     = {{(LENW-1){1'b0}}, 1'b1} << win_log2;
    end
    addr = (img_row << n_log2) | img_col;
  end

endmodule

// File: rtl/dft_tile_seq.sv
module dft_tile_seq #(
  parameter int MAX_N_LOG2 = 6,
  localparam int LW   = $clog2(MAX_N_LOG2 + 1),
  localparam int CW   = MAX_N_LOG2,
  localparam int AW   = 2 * MAX_N_LOG2,
  localparam int LENW = MAX_N_LOG2 + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            cfg_phase,
  input  logic [LW-1:0]   cfg_n_log2,
  input  logic [LW-1:0]   cfg_k_log2,
  input  logic [LW-1:0]   cfg_s_log2,
  output logic            busy,
  output logic            req_valid,
  input  logic            req_ready,
  output logic            req_write,
  output logic [AW-1:0]   req_addr,
  output logic [LENW-1:0] req_len,
  output logic            tile_ready,
  input  logic            cmp_done,
  output logic            done
);
  import dft_tseq_pkg::*;

  seq_state_e    st;
  phase_e        ph_q;
  logic [LW-1:0] nl_q, kl_q, sl_q;
  logic          wr_q;

  logic [LW-1:0] ctr_lim  [N_CTR];
  logic          ctr_adv  [N_CTR];
  logic [CW-1:0] ctr_cnt  [N_CTR];
  logic          ctr_last [N_CTR];

  logic            accept, launch, walk_last, tile_step, tiles_last;
  logic [AW-1:0]   map_addr;
  logic [LENW-1:0] map_len;

  assign busy      = (st != ST_IDLE);
  assign launch    = (st == ST_IDLE) && start;
  assign accept    = (st == ST_ISSUE) && req_valid && req_ready;
  assign walk_last = ctr_last[CTR_SEG] && ctr_last[CTR_ROW];
  assign tile_step = accept && walk_last && wr_q;
  assign tiles_last = ctr_last[CTR_TX] && ctr_last[CTR_TY];

  // limits of the nested walk: segment, tile row, tile column, tile row index
  assign ctr_lim[CTR_SEG] = (ph_q == PH_LOCAL) ? '0 : (nl_q - kl_q);
  assign ctr_lim[CTR_ROW] = sl_q;
  assign ctr_lim[CTR_TX]  = nl_q - sl_q;
  assign ctr_lim[CTR_TY]  = nl_q - sl_q;

  assign ctr_adv[CTR_SEG] = accept;
  assign ctr_adv[CTR_ROW] = accept && ctr_last[CTR_SEG];
  assign ctr_adv[CTR_TX]  = tile_step;
  assign ctr_adv[CTR_TY]  = tile_step && ctr_last[CTR_TX];

  for (genvar g = 0; g < N_CTR; g++) begin : g_walk
    dft_tseq_wrapctr #(.CW(CW), .LW(LW)) ctr_i (
      .clk      (clk),
      .rst      (rst),
      .clr      (launch),
      .adv      (ctr_adv[g]),
      .lim_log2 (ctr_lim[g]),
      .cnt      (ctr_cnt[g]),
      .last     (ctr_last[g])
    );
  end

  dft_tseq_addr_map #(.MAX_N_LOG2(MAX_N_LOG2)) map_i (
    .phase  (ph_q),
    .n_log2 (nl_q),
    .k_log2 (kl_q),
    .s_log2 (sl_q),
    .row_i  (ctr_cnt[CTR_ROW]),
    .seg_j  (ctr_cnt[CTR_SEG]),
    .tile_y (ctr_cnt[CTR_TY]),
    .tile_x (ctr_cnt[CTR_TX]),
    .addr   (map_addr),
    .len    (map_len)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      ph_q       <= PH_EXCH;
      nl_q       <= '0;
      kl_q       <= '0;
      sl_q       <= '0;
      wr_q       <= 1'b0;
      req_valid  <= 1'b0;
      req_write  <= 1'b0;
      req_addr   <= '0;
      req_len    <= '0;
      tile_ready <= 1'b0;
      done       <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (start) begin
            ph_q <= phase_e'(cfg_phase);
            nl_q <= cfg_n_log2;
            kl_q <= cfg_k_log2;
            sl_q <= cfg_s_log2;
            wr_q <= 1'b0;
            st   <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (!req_valid) begin
            req_valid <= 1'b1;
            req_addr  <= map_addr;
            req_len   <= map_len;
            req_write <= wr_q;
          end else if (req_ready) begin
            req_valid <= 1'b0;
            if (walk_last) begin
              if (!wr_q) begin
                tile_ready <= 1'b1;
                st         <= ST_HOLD;
              end else if (tiles_last) begin
                done <= 1'b1;
                st   <= ST_IDLE;
              end else begin
                wr_q <= 1'b0;
              end
            end
          end
        end
        ST_HOLD: begin
          if (cmp_done) begin
            tile_ready <= 1'b0;
            wr_q       <= 1'b1;
            st         <= ST_ISSUE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // ---------------- assertions ----------------
  logic [AW:0] row_off;
  logic [AW:0] row_span;
  assign row_off  = {1'b0, req_addr & ((({{(AW-1){1'b0}}, 1'b1}) << nl_q) - {{(AW-1){1'b0}}, 1'b1})};
  assign row_span = {{(AW){1'b0}}, 1'b1} << nl_q;

  a_r5_within_row: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (row_off + {{(AW+1-LENW){1'b0}}, req_len}) <= row_span);

  a_r11_hold_stable: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)
                                   && $stable(req_len) && $stable(req_write)));

  a_r8_quiet_in_compute: assert property (@(posedge clk) disable iff (rst)
    tile_ready |-> !req_valid);

  a_r8_hold_until_cmp: assert property (@(posedge clk) disable iff (rst)
    (tile_ready && !cmp_done) |=> tile_ready);

  a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r9_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  a_r10_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(nl_q) && $stable(kl_q)
                               && $stable(sl_q) && $stable(ph_q)));

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!req_valid && !tile_ready));

endmodule

// File: tb/dft_tile_seq_tb_top.sv
module dft_tile_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int MAXL = 6;
  localparam int LW   = $clog2(MAXL + 1);
  localparam int AW   = 2 * MAXL;
  localparam int LENW = MAXL + 1;
  localparam int LOGD = 1024;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            start = 1'b0;
  logic            cfg_phase = 1'b0;
  logic [LW-1:0]   cfg_n_log2 = '0;
  logic [LW-1:0]   cfg_k_log2 = '0;
  logic [LW-1:0]   cfg_s_log2 = '0;
  logic            busy, req_valid, req_write, tile_ready, done;
  logic            req_ready = 1'b0;
  logic            cmp_done = 1'b0;
  logic [AW-1:0]   req_addr;
  logic [LENW-1:0] req_len;

  dft_tile_seq #(.MAX_N_LOG2(MAXL)) dut_i (
    .clk(clk), .rst(rst), .start(start), .cfg_phase(cfg_phase),
    .cfg_n_log2(cfg_n_log2), .cfg_k_log2(cfg_k_log2), .cfg_s_log2(cfg_s_log2),
    .busy(busy), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_len(req_len),
    .tile_ready(tile_ready), .cmp_done(cmp_done), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;

  // observed traffic
  int log_addr [LOGD];
  int log_len  [LOGD];
  int log_wr   [LOGD];
  int log_n    = 0;
  int mark_pos [LOGD];
  int mark_n   = 0;
  int done_cnt = 0;
  int quiet_viol = 0;
  int stall_viol = 0;
  int ready_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic        prev_stall = 1'b0;
  logic [AW-1:0]   prev_addr = '0;
  logic [LENW-1:0] prev_len  = '0;
  logic            prev_wr   = 1'b0;
  logic            tr_prev   = 1'b0;

  // expected traffic
  int exp_addr [LOGD];
  int exp_len  [LOGD];
  int exp_wr   [LOGD];
  int exp_n    = 0;
  int exp_bpt  = 0;
  int exp_tiles = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // memory-side model: drives ready, records accepted bursts
  always @(negedge clk) begin
    logic nr;
    if (rst) begin
      req_ready  = 1'b0;
      prev_stall = 1'b0;
      tr_prev    = 1'b0;
    end else begin
      if (prev_stall) begin
        if (!(req_valid && req_addr == prev_addr && req_len == prev_len
              && req_write == prev_wr)) stall_viol++;
      end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      nr = (ready_mode == 0) ? 1'b1 : (lfsr[0] & lfsr[3]);
      req_ready = nr;
      if (req_valid && nr && log_n < LOGD) begin
        log_addr[log_n] = int'(req_addr);
        log_len[log_n]  = int'(req_len);
        log_wr[log_n]   = int'(req_write);
        log_n++;
      end
      prev_stall = req_valid && !nr;
      prev_addr  = req_addr;
      prev_len   = req_len;
      prev_wr    = req_write;
      if (tile_ready && !tr_prev && mark_n < LOGD) begin
        mark_pos[mark_n] = log_n;
        mark_n++;
      end
      tr_prev = tile_ready;
      if (tile_ready && req_valid) quiet_viol++;
      if (done) begin
        done_cnt++;
        if (busy) quiet_viol++;
      end
    end
  end

  // compute-side model: answers tile_ready after a short delay
  int hold_cnt = 0;
  always @(negedge clk) begin
    if (cmp_done) begin
      cmp_done = 1'b0;
      hold_cnt = 0;
    end else if (tile_ready) begin
      hold_cnt++;
      if (hold_cnt == 4) cmp_done = 1'b1;
    end else begin
      hold_cnt = 0;
    end
  end

  task automatic build_expected(input int ph, input int nl, input int kl, input int sl);
    int nn, kk, ss, mm, ww, tt;
    nn = 1 << nl; kk = 1 << kl; ss = 1 << sl;
    mm = nn / kk; ww = ss / mm; tt = nn / ss;
    exp_n = 0;
    exp_tiles = tt * tt;
    exp_bpt = (ph == 1) ? ss : ss * mm;
    for (int ty = 0; ty < tt; ty++)
      for (int tx = 0; tx < tt; tx++)
        for (int wr = 0; wr < 2; wr++) begin
          if (ph == 1) begin
            for (int r = 0; r < ss; r++) begin
              exp_addr[exp_n] = (ty*ss + r)*nn + tx*ss;
              exp_len[exp_n]  = ss;
              exp_wr[exp_n]   = wr;
              exp_n++;
            end
          end else begin
            for (int br = 0; br < mm; br++)
              for (int r = 0; r < ww; r++)
                for (int bc = 0; bc < mm; bc++) begin
                  exp_addr[exp_n] = (br*kk + ty*ww + r)*nn + bc*kk + tx*ww;
                  exp_len[exp_n]  = ww;
                  exp_wr[exp_n]   = wr;
                  exp_n++;
                end
          end
        end
  endtask

  task automatic run_job(input string name, input string req, input int ph,
                         input int nl, input int kl, input int sl,
                         input int mode, input bit inject);
    int guard, bad, first;
    build_expected(ph, nl, kl, sl);
    log_n = 0; mark_n = 0; done_cnt = 0; quiet_viol = 0; stall_viol = 0;
    ready_mode = mode;
    @(negedge clk);
    cfg_phase = ph[0]; cfg_n_log2 = LW'(nl); cfg_k_log2 = LW'(kl); cfg_s_log2 = LW'(sl);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2", {name, " busy after start"}, int'(busy), 1);
    if (inject) begin
      // R10: a second start with a different setup mid-run
      repeat (25) @(negedge clk);
      cfg_phase = ~cfg_phase; cfg_s_log2 = cfg_s_log2 - 1'b1;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    guard = 0;
    while (done_cnt == 0 && guard < 40000) begin
      @(negedge clk);
      guard++;
    end
    repeat (3) @(negedge clk);
    chk(done_cnt == 1, "R9", {name, " done pulses"}, done_cnt, 1);
    chk(busy == 1'b0, "R9", {name, " busy after done"}, int'(busy), 0);
    chk(log_n == exp_n, "R5", {name, " burst count"}, log_n, exp_n);
    bad = 0; first = -1;
    for (int e = 0; e < exp_n && e < log_n; e++) begin
      if (log_addr[e] != exp_addr[e] || log_len[e] != exp_len[e] || log_wr[e] != exp_wr[e]) begin
        if (first < 0) first = e;
        bad++;
      end
    end
    if (first >= 0)
      chk(1'b0, req, {name, " burst addr at first mismatch (R7 covers write copies)"},
          log_addr[first], exp_addr[first]);
    else
      chk(1'b1, req, {name, " burst sequence"}, 0, 0);
    if (req == "R10") chk(bad == 0, "R10", {name, " sequence unaffected by start"}, bad, 0);
    chk(mark_n == exp_tiles, "R6", {name, " tiles computed"}, mark_n, exp_tiles);
    bad = 0;
    for (int t = 0; t < mark_n; t++)
      if (mark_pos[t] != (2*t + 1) * exp_bpt) bad++;
    chk(bad == 0, "R8", {name, " tile_ready after last read"}, bad, 0);
    chk(quiet_viol == 0, "R8", {name, " requests while tile_ready or busy at done"}, quiet_viol, 0);
    chk(stall_viol == 0, "R11", {name, " request changed while stalled"}, stall_viol, 0);
  endtask

  task automatic test_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0,       "R1", "busy in reset", int'(busy), 0);
    chk(req_valid == 1'b0,  "R1", "req_valid in reset", int'(req_valid), 0);
    chk(tile_ready == 1'b0, "R1", "tile_ready in reset", int'(tile_ready), 0);
    chk(done == 1'b0,       "R1", "done in reset", int'(done), 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk(req_valid == 1'b0,  "R1", "req_valid idle after reset", int'(req_valid), 0);
  endtask

  // watchdog
  initial begin
    #(CLK_PERIOD * 190000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    test_reset();
    // R3: local pass, 16x16 image, 4x4 sub-blocks, 8x8 tiles
    run_job("local_n16", "R3", 1, 4, 2, 3, 0, 1'b0);
    // R4: exchange pass with back-pressure, mesh 4, window 2
    run_job("exch_n16_bp", "R4", 0, 4, 2, 3, 1, 1'b0);
    // R4: exchange pass, mesh as wide as tile, one-word bursts
    run_job("exch_w1", "R4", 0, 4, 1, 3, 1, 1'b0);
    // R10: exchange pass, window 4, start injected mid-run
    run_job("exch_n32_inj", "R10", 0, 5, 3, 4, 0, 1'b1);
    // R6: local pass, single tile covering the whole image
    run_job("local_single", "R6", 1, 3, 2, 3, 1, 1'b0);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule